// File: doc/BRIEF.md
# Two-Stage Locked Watchdog Timer

This block is a watchdog with two down-counting stages that run one after the other. When enabled, the first stage counts ticks down from its preload value. When it expires it sets an interrupt status flag and, unless the interrupt is turned off, drives an interrupt line. Counting then moves to the second stage, which starts from its own preload. When the second stage expires, the block pulses a reset request for one clock, sets a sticky timed-out flag and starts over with the first stage. Software keeps the watchdog from expiring by issuing reload commands, each of which restarts the first stage.

The two preload registers and the reload register are write-protected. A write takes effect only right after a two-write key sequence to the reload register, and each key sequence opens exactly one write. A separate byte-wide configuration port selects the tick rate and turns off the interrupt or the reset output. A lock port carries the enable bit, a plain-timer mode bit and a lock bit. Once set, the lock bit keeps the watchdog from being stopped until the next hardware reset.

Ticks come from a prescaler on the input clock: either 2^SLOW_SHIFT clocks per tick (default 15, about 1 kHz) or 2^FAST_SHIFT clocks per tick (default 5). A preload of P gives a stage that lasts P ticks, and a preload of 0 behaves as 1.

Top module: `wdt2_guard`

## Requirements
- R1: After reset, preload A (offset 0x0) and preload B (offset 0x4) read PRE1_RST and PRE2_RST. The status register (0x8), the reload register (0xC), the config byte and the lock byte all read 0, and irq and rst_req are low.
- R2: Writing 0x80 and then 0x86 to offset 0xC opens the protection. The next single write to 0x0, 0x4 or 0xC takes effect, and the protection closes again straight after it.
- R3: A write to a protected offset while the protection is closed has no effect. A write during the key sequence that does not continue it (wrong value or other offset) returns the sequencer to closed.
- R4: An admitted write to 0xC with bit 8 set restarts stage A from preload A and restarts the tick prescaler. Periodic reloads keep stage A from expiring.
- R5: With enable set, stage A expires exactly P_A*DIV clocks after the start (where P_A = max(preload A,1)). The expiry sets status bit 0 (read at 0x8, cleared by writing 1 to bit 0 of 0x8, no unlock needed), and the count then moves to stage B.
- R6: Stage B expires P_B*DIV clocks after stage A expired. The expiry sets the timed-out flag (bit 9 of 0xC) and pulses rst_req high for exactly one clock, unless config bit 5 or lock bit 2 (plain-timer mode) is 1.
- R7: Config bit 2 = 0 selects DIV = 2^SLOW_SHIFT clocks per tick, and config bit 2 = 1 selects DIV = 2^FAST_SHIFT.
- R8: Lock bit 1 is the enable. While it is 0 the stages do not advance, and clearing it stops the watchdog, which reads back as lock bit 1 = 0.
- R9: Lock bit 0 is sticky: once it is set, writes can clear neither lock bit 0 nor lock bit 1 until reset.
- R10: The timed-out flag survives a reload command and ignores unprotected writes. An admitted write to 0xC with bit 9 set clears it, and reset clears it when TOUT_POR_CLR = 1.
- R11: Config bits 1:0 = 11 keep irq low, while status bit 0 is still set on stage A expiry. Any other value makes irq follow status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 4 | Register byte offset (0x0, 0x4, 0x8, 0xC) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| cfg_wr | input | 1 | Config byte write strobe |
| cfg_wdata | input | 8 | Config byte write data |
| cfg_rdata | output | 8 | Config byte read data |
| lck_wr | input | 1 | Lock byte write strobe |
| lck_wdata | input | 8 | Lock byte write data |
| lck_rdata | output | 8 | Lock byte read data |
| irq | output | 1 | Stage A interrupt |
| rst_req | output | 1 | One-clock reset request on stage B expiry |

## Verification
On every cycle the assertions check the following. The reset request is a single-cycle pulse and only occurs together with the timed-out flag. The lock bit never drops, and the enable bit never drops while the lock bit is set. The count does not move while the watchdog is disabled and no reload is issued. A preload write outside an open unlock window leaves the preload unchanged, and each admitted write closes the window. Only the bench scenarios can show the exact expiry cycle counts for each pair of preloads and each tick rate, the abort of a partial key sequence, keep-alive pinging, and the effect of the config and plain-timer bits on irq and rst_req.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    // register byte offsets; software depends on these positions
    localparam logic [3:0] OFS_PRE1 = 4'h0;
    localparam logic [3:0] OFS_PRE2 = 4'h4;
    localparam logic [3:0] OFS_STAT = 4'h8;
    localparam logic [3:0] OFS_RLD  = 4'hC;

    // two-step key written to the reload offset
    localparam logic [31:0] KEY_FIRST  = 32'h0000_0080;
    localparam logic [31:0] KEY_SECOND = 32'h0000_0086;

    localparam int RLD_CMD_BIT  = 8;
    localparam int RLD_TOUT_BIT = 9;

    typedef enum logic [1:0] {
        UL_LOCKED = 2'd0,
        UL_HALF   = 2'd1,
        UL_OPEN   = 2'd2
    } unlock_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic       rst_out_off;
        logic       fast_tick;
        logic [1:0] int_type;
    } cfg_t;

    typedef struct packed {
        logic timer_mode;
        logic enable;
        logic lock;
    } lck_t;

    function automatic cfg_t cfg_unpack(logic [7:0] d);
        cfg_t c;
        c.rst_out_off = d[5];
        c.fast_tick   = d[2];
        c.int_type    = d[1:0];
        return c;
    endfunction

    function automatic logic [7:0] cfg_pack(cfg_t c);
        return {2'b00, c.rst_out_off, 2'b00, c.fast_tick, c.int_type};
    endfunction

    function automatic lck_t lck_unpack(logic [7:0] d);
        lck_t l;
        l.timer_mode = d[2];
        l.enable     = d[1];
        l.lock       = d[0];
        return l;
    endfunction

    function automatic logic [7:0] lck_pack(lck_t l);
        return {5'b00000, l.timer_mode, l.enable, l.lock};
    endfunction

    function automatic logic is_protected(logic [3:0] a);
        return (a == OFS_PRE1) || (a == OFS_PRE2) || (a == OFS_RLD);
    endfunction

endpackage

// File: rtl/wdt2_unlock.sv
module wdt2_unlock
    import wdt2_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [3:0]  addr,
    input  logic [31:0] data,
    output logic        grant,
    output unlock_e     state
);

    unlock_e st_q, st_d;

    always_comb begin
        st_d  = st_q;
        grant = 1'b0;
        if (wr) begin
            case (st_q)
                UL_LOCKED: st_d = (addr == OFS_RLD && data == KEY_FIRST) ? UL_HALF : UL_LOCKED;
                UL_HALF:   st_d = (addr == OFS_RLD && data == KEY_SECOND) ? UL_OPEN : UL_LOCKED;
                UL_OPEN: begin
                    grant = is_protected(addr);
                    st_d  = UL_LOCKED;
                end
                default:   st_d = UL_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= UL_LOCKED;
        else     st_q <= st_d;
    end

    assign state = st_q;

endmodule

// File: rtl/wdt2_tick.sv
module wdt2_tick #(
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    input  logic fast,
    output logic tick
);

    localparam int W = SLOW_SHIFT;
    localparam logic [W-1:0] FAST_MASK = W'((1 << FAST_SHIFT) - 1);
    localparam logic [W-1:0] SLOW_MASK = '1;

    logic [W-1:0] div_q;
    logic [W-1:0] mask;

    assign mask = fast ? FAST_MASK : SLOW_MASK;
    assign tick = run && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) div_q <= '0;
        else                      div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/wdt2_stages.sv
module wdt2_stages
    import wdt2_pkg::*;
#(
    parameter int              CNT_W    = 20,
    parameter logic [CNT_W-1:0] PRE1_RST = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    output logic             s1_exp,
    output logic             s2_exp,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;
    phase_e           ph_q;
    logic             last;

    // a preload of 0 or 1 both end on the first tick
    assign last   = (cnt_q <= CNT_W'(1));
    assign s1_exp = tick && !restart && last && (ph_q == PH_FIRST);
    assign s2_exp = tick && !restart && last && (ph_q == PH_SECOND);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= PRE1_RST;
            ph_q  <= PH_FIRST;
        end else if (restart) begin
            cnt_q <= pre1;
            ph_q  <= PH_FIRST;
        end else if (s1_exp) begin
            cnt_q <= pre2;
            ph_q  <= PH_SECOND;
        end else if (s2_exp) begin
            cnt_q <= pre1;
            ph_q  <= PH_FIRST;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/wdt2_guard.sv
module wdt2_guard
    import wdt2_pkg::*;
#(
    parameter int               CNT_W        = 20,
    parameter int               SLOW_SHIFT   = 15,
    parameter int               FAST_SHIFT   = 5,
    parameter logic [CNT_W-1:0] PRE1_RST     = CNT_W'(30 << 9),
    parameter logic [CNT_W-1:0] PRE2_RST     = CNT_W'(30 << 9),
    parameter bit               TOUT_POR_CLR = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic        lck_wr,
    input  logic [7:0]  lck_wdata,
    output logic [7:0]  lck_rdata,
    output logic        irq,
    output logic        rst_req
);

    logic             grant;
    unlock_e          ul_state;
    logic             restart;
    logic             tout_clr;
    logic             tick;
    logic             s1_exp;
    logic             s2_exp;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] pre1_q;
    logic [CNT_W-1:0] pre2_q;
    logic             s1_flag_q;
    logic             tout_q;
    logic             tout_d;
    logic             rst_req_q;
    cfg_t             cfg_q;
    lck_t             lck_q;
    lck_t             lck_d;
    lck_t             lck_in;

    wdt2_unlock u_unlock (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .data  (reg_wdata),
        .grant (grant),
        .state (ul_state)
    );

    assign restart  = grant && (reg_addr == OFS_RLD) && reg_wdata[RLD_CMD_BIT];
    assign tout_clr = grant && (reg_addr == OFS_RLD) && reg_wdata[RLD_TOUT_BIT];

    wdt2_tick #(
        .SLOW_SHIFT (SLOW_SHIFT),
        .FAST_SHIFT (FAST_SHIFT)
    ) u_tick (
        .clk   (clk),
        .rst   (rst),
        .run   (lck_q.enable),
        .clear (restart),
        .fast  (cfg_q.fast_tick),
        .tick  (tick)
    );

    wdt2_stages #(
        .CNT_W    (CNT_W),
        .PRE1_RST (PRE1_RST)
    ) u_stages (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (restart),
        .pre1    (pre1_q),
        .pre2    (pre2_q),
        .s1_exp  (s1_exp),
        .s2_exp  (s2_exp),
        .cnt     (cnt)
    );

    // protected preloads
    always_ff @(posedge clk) begin
        if (rst) begin
            pre1_q <= PRE1_RST;
            pre2_q <= PRE2_RST;
        end else if (grant) begin
            if (reg_addr == OFS_PRE1) pre1_q <= reg_wdata[CNT_W-1:0];
            if (reg_addr == OFS_PRE2) pre2_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // stage A status: set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst)
            s1_flag_q <= 1'b0;
        else if (s1_exp)
            s1_flag_q <= 1'b1;
        else if (reg_wr && reg_addr == OFS_STAT && reg_wdata[0])
            s1_flag_q <= 1'b0;
    end

    assign tout_d = s2_exp ? 1'b1 : (tout_clr ? 1'b0 : tout_q);

    generate
        if (TOUT_POR_CLR) begin : g_tout_por
            always_ff @(posedge clk) begin
                if (rst) tout_q <= 1'b0;
                else     tout_q <= tout_d;
            end
        end else begin : g_tout_keep
            always_ff @(posedge clk) begin
                tout_q <= tout_d;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) rst_req_q <= 1'b0;
        else     rst_req_q <= s2_exp && !cfg_q.rst_out_off && !lck_q.timer_mode;
    end

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_unpack(cfg_wdata);
    end

    assign lck_in = lck_unpack(lck_wdata);

    always_comb begin
        lck_d = lck_q;
        if (lck_wr) begin
            if (lck_q.lock) begin
                lck_d.lock       = 1'b1;
                lck_d.enable     = lck_q.enable | lck_in.enable;
                lck_d.timer_mode = lck_q.timer_mode;
            end else begin
                lck_d = lck_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lck_q <= '0;
        else     lck_q <= lck_d;
    end

    always_comb begin
        case (reg_addr)
            OFS_PRE1: reg_rdata = 32'(pre1_q);
            OFS_PRE2: reg_rdata = 32'(pre2_q);
            OFS_STAT: reg_rdata = {31'd0, s1_flag_q};
            OFS_RLD:  reg_rdata = 32'(tout_q) << RLD_TOUT_BIT;
            default:  reg_rdata = 32'd0;
        endcase
    end

    assign cfg_rdata = cfg_pack(cfg_q);
    assign lck_rdata = lck_pack(lck_q);
    assign irq       = s1_flag_q && (cfg_q.int_type != 2'b11);
    assign rst_req   = rst_req_q;

endmodule

module wdt2_guard_chk
    import wdt2_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [3:0]       reg_addr,
    input logic             rst_req,
    input logic             tout,
    input logic             lock,
    input logic             enable,
    input logic             restart,
    input logic             grant,
    input unlock_e          ul_state,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] pre1
);

    // R6
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R6
    rst_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> tout);

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);

    // R9
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && enable) |=> enable);

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable && !restart) |=> $stable(cnt));

    // R3
    locked_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_PRE1 && ul_state != UL_OPEN) |=> $stable(pre1));

    // R2
    relock_chk: assert property (@(posedge clk) disable iff (rst)
        grant |=> (ul_state == UL_LOCKED));

endmodule

bind wdt2_guard wdt2_guard_chk #(.CNT_W(CNT_W)) u_guard_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .rst_req  (rst_req),
    .tout     (tout_q),
    .lock     (lck_q.lock),
    .enable   (lck_q.enable),
    .restart  (restart),
    .grant    (grant),
    .ul_state (ul_state),
    .cnt      (cnt),
    .pre1     (pre1_q)
);

// File: tb/test_wdt2_guard.sv
module test_wdt2_guard;
    import wdt2_pkg::*;

    localparam int CNT_W = 12;
    localparam int SLOW  = 4;
    localparam int FAST  = 1;
    localparam int SDIV  = 1 << SLOW;
    localparam int FDIV  = 1 << FAST;
    localparam logic [CNT_W-1:0] P1R = 12'd5;
    localparam logic [CNT_W-1:0] P2R = 12'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic [7:0]  cfg_rdata;
    logic        lck_wr = 1'b0;
    logic [7:0]  lck_wdata = 8'd0;
    logic [7:0]  lck_rdata;
    logic        irq;
    logic        rst_req;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    wdt2_guard #(
        .CNT_W      (CNT_W),
        .SLOW_SHIFT (SLOW),
        .FAST_SHIFT (FAST),
        .PRE1_RST   (P1R),
        .PRE2_RST   (P2R)
    ) i_wdt2_guard (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .lck_wr    (lck_wr),
        .lck_wdata (lck_wdata),
        .lck_rdata (lck_rdata),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 30000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired act=%0d exp=<30000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic unlock();
        wr_reg(OFS_RLD, KEY_FIRST);
        wr_reg(OFS_RLD, KEY_SECOND);
    endtask

    task automatic wr_cfg(input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr_lck(input logic [7:0] d);
        @(negedge clk);
        lck_wr = 1'b1; lck_wdata = d;
        @(negedge clk);
        lck_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // disable, program preloads and config, clear flags; counters stay frozen
    task automatic prep(input int p1, input int p2, input logic [7:0] c);
        wr_lck(8'h00);
        wr_cfg(c);
        unlock(); wr_reg(OFS_PRE1, 32'(p1));
        unlock(); wr_reg(OFS_PRE2, 32'(p2));
        unlock(); wr_reg(OFS_RLD, 32'h300);
        wr_reg(OFS_STAT, 32'h1);
    endtask

    // k counts clocks after the start edge; 0 means never seen
    task automatic watch(input int limit, output int kf, output int ki, output int kr, output int rw);
        kf = 0; ki = 0; kr = 0; rw = 0;
        reg_addr = OFS_STAT;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if (kf == 0 && reg_rdata[0]) kf = k;
            if (ki == 0 && irq) ki = k;
            if (rst_req) begin
                rw = rw + 1;
                if (kr == 0) kr = k;
            end
        end
    endtask

    initial begin
        logic [31:0] v;
        int kf, ki, kr, rw, e1, div;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(OFS_PRE1, v); chk("R1 pre1", v, 32'(P1R));
        rd_reg(OFS_PRE2, v); chk("R1 pre2", v, 32'(P2R));
        rd_reg(OFS_STAT, v); chk("R1 status", v, 32'd0);
        rd_reg(OFS_RLD, v);  chk("R1 reload", v, 32'd0);
        chk("R1 cfg", 32'(cfg_rdata), 32'd0);
        chk("R1 lock", 32'(lck_rdata), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 rst_req", 32'(rst_req), 32'd0);

        // R3 locked write ignored, partial key aborted
        wr_reg(OFS_PRE1, 32'd3);
        rd_reg(OFS_PRE1, v); chk("R3 locked write", v, 32'(P1R));
        wr_reg(OFS_RLD, KEY_FIRST);
        wr_reg(OFS_PRE1, 32'd3);
        rd_reg(OFS_PRE1, v); chk("R3 half key", v, 32'(P1R));
        wr_reg(OFS_RLD, KEY_SECOND);
        wr_reg(OFS_PRE1, 32'd3);
        rd_reg(OFS_PRE1, v); chk("R3 aborted key", v, 32'(P1R));
        wr_reg(OFS_RLD, KEY_FIRST);
        wr_reg(OFS_STAT, 32'h0);
        wr_reg(OFS_RLD, KEY_SECOND);
        wr_reg(OFS_PRE2, 32'd3);
        rd_reg(OFS_PRE2, v); chk("R3 other offset aborts", v, 32'(P2R));

        // R2 one write per unlock
        unlock(); wr_reg(OFS_PRE1, 32'd9);
        rd_reg(OFS_PRE1, v); chk("R2 unlocked write", v, 32'd9);
        wr_reg(OFS_PRE1, 32'd4);
        rd_reg(OFS_PRE1, v); chk("R2 second write blocked", v, 32'd9);
        unlock(); wr_reg(OFS_PRE2, 32'd11);
        rd_reg(OFS_PRE2, v); chk("R2 preload B write", v, 32'd11);

        // R5 R6 R7 sweep in fast mode, preload A including 0
        for (int p1 = 0; p1 <= 3; p1++) begin
            for (int p2 = 1; p2 <= 3; p2++) begin
                e1 = (p1 == 0) ? 1 : p1;
                prep(p1, p2, 8'h04);
                wr_lck(8'h02);
                watch((e1 + p2) * FDIV + 2, kf, ki, kr, rw);
                chk($sformatf("R5 flag p1=%0d p2=%0d", p1, p2), 32'(kf), 32'(e1 * FDIV));
                chk($sformatf("R5 irq p1=%0d p2=%0d", p1, p2), 32'(ki), 32'(e1 * FDIV));
                chk($sformatf("R6 rst p1=%0d p2=%0d", p1, p2), 32'(kr), 32'((e1 + p2) * FDIV));
                chk($sformatf("R6 rst width p1=%0d p2=%0d", p1, p2), 32'(rw), 32'd1);
                rd_reg(OFS_RLD, v);
                chk("R6 timed-out flag", v, 32'h200);
            end
        end

        // R7 slow tick
        div = SDIV;
        prep(2, 1, 8'h00);
        wr_lck(8'h02);
        watch(3 * div + 2, kf, ki, kr, rw);
        chk("R7 slow stage A", 32'(kf), 32'(2 * div));
        chk("R7 slow stage B", 32'(kr), 32'(3 * div));

        // R10 timed-out flag survives reload, needs unlock to clear
        unlock(); wr_reg(OFS_RLD, 32'h100);
        rd_reg(OFS_RLD, v); chk("R10 survives reload", v, 32'h200);
        wr_reg(OFS_RLD, 32'h200);
        rd_reg(OFS_RLD, v); chk("R10 locked clear ignored", v, 32'h200);
        unlock(); wr_reg(OFS_RLD, 32'h200);
        rd_reg(OFS_RLD, v); chk("R10 unlocked clear", v, 32'h0);

        // R11 interrupt type 11 keeps irq low
        prep(2, 1, 8'h07);
        wr_lck(8'h02);
        watch(3 * FDIV + 2, kf, ki, kr, rw);
        chk("R11 status still set", 32'(kf), 32'(2 * FDIV));
        chk("R11 irq off", 32'(ki), 32'd0);
        chk("R11 rst unaffected", 32'(kr), 32'(3 * FDIV));

        // R6 reset output off by config bit 5
        prep(2, 1, 8'h24);
        wr_lck(8'h02);
        watch(3 * FDIV + 2, kf, ki, kr, rw);
        chk("R6 cfg bit5 no rst_req", 32'(rw), 32'd0);
        rd_reg(OFS_RLD, v); chk("R6 cfg bit5 flag set", v, 32'h200);

        // R6 plain-timer mode (lock bit 2)
        prep(1, 1, 8'h04);
        wr_lck(8'h06);
        watch(2 * FDIV + 2, kf, ki, kr, rw);
        chk("R6 timer mode no rst_req", 32'(rw), 32'd0);
        rd_reg(OFS_RLD, v); chk("R6 timer mode flag set", v, 32'h200);

        // R4 pinging holds off stage A, then expiry from the last reload
        prep(5, 2, 8'h04);
        wr_lck(8'h02);
        for (int n = 0; n < 8; n++) begin
            unlock(); wr_reg(OFS_RLD, 32'h100);
        end
        watch(5 * FDIV + 1, kf, ki, kr, rw);
        chk("R4 expiry after last reload", 32'(kf), 32'(5 * FDIV));

        // R8 stop before expiry freezes the count
        prep(2, 1, 8'h04);
        wr_lck(8'h02);
        wr_lck(8'h00);
        chk("R8 enable reads 0", 32'(lck_rdata[1]), 32'd0);
        watch(40, kf, ki, kr, rw);
        chk("R8 no stage A when stopped", 32'(kf), 32'd0);
        chk("R8 no rst when stopped", 32'(rw), 32'd0);

        // R9 lock is sticky, reset clears lock and flag
        prep(2, 1, 8'h04);
        wr_lck(8'h03);
        wr_lck(8'h00);
        chk("R9 lock and enable kept", 32'(lck_rdata), 32'h03);
        watch(20, kf, ki, kr, rw);
        chk("R9 still running", 32'(rw >= 1), 32'd1);
        rd_reg(OFS_RLD, v); chk("R10 flag before reset", v, 32'h200);
        do_reset();
        chk("R9 lock cleared by reset", 32'(lck_rdata), 32'd0);
        rd_reg(OFS_RLD, v); chk("R10 reset clears flag", v, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule